// File: doc/BRIEF.md
# Modulus Down-Counter with Capture Polarity Status

This block is a 16-bit down-counter that repeats a programmable period. A two-bit select picks the count rate: the counter steps once every 1, 4, 8 or 16 clocks. Software writes a modulus value, and the counter starts from that value. When the counter steps from one to zero, it raises a sticky underflow flag. On the next step after zero, it reloads the stored modulus and keeps counting. An interrupt request follows the flag, gated by an enable input.

The same 8-bit status word also reports four capture polarity bits, one for each input-capture channel. A channel's bit records the direction of the first capture edge that arrives after that channel's capture latch was read. Later captures leave the bit alone until the next latch read. The flag is cleared in one of two ways, chosen by a fast-clear mode input:
- In normal mode, software writes a one to the flag bit.
- In fast-clear mode, software reads the counter, which the capture logic signals with a strobe.

Top module: `mdcnt_top`

## Requirements
- R1: Select code 0, 1, 2 and 3 (`presel_wdata`) makes the counter decrement once every 1, 4, 8 and 16 clocks respectively. Writing the select restarts the rate divider.
- R2: A load write sets the counter and the stored modulus to `load_wdata` on the next edge and restarts the rate divider. The first decrement then follows after one full divide period.
- R3: A step from 1 to 0 sets the underflow flag. The next step from 0 reloads the stored modulus. With a modulus of 0 the counter stays at 0 and never sets the flag.
- R4: With `fast_clr` low, a status write with bit 7 set clears the flag. A status write with bit 7 clear leaves it unchanged. `cnt_rd` has no effect on the flag.
- R5: With `fast_clr` high, a status write with bit 7 set does not clear the flag, and a `cnt_rd` pulse clears it.
- R6: When a flag set and a flag clear fall in the same cycle, the flag ends up set.
- R7: A channel's polarity bit takes `cap_edge` (1 = rising, 0 = falling) from the first `cap_evt` after that channel's `latch_rd`. It ignores later events until the next `latch_rd`. After reset, every channel accepts its first event.
- R8: A `latch_rd` and a `cap_evt` on the same channel in the same cycle record that event, and the channel then ignores further events.
- R9: `stat_rdata` has the flag at bit 7, bits 6..4 read zero, and channels 3..0 at bits 3..0. Writes to bits 6..0 have no effect, and every bit resets to 0.
- R10: `irq` is high exactly when the flag is set and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presel_we | input | 1 | Rate select write strobe |
| presel_wdata | input | 2 | Rate select code |
| load_we | input | 1 | Modulus load strobe |
| load_wdata | input | 16 | Modulus value |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data |
| stat_rdata | output | 8 | Status word |
| cnt_rd | input | 1 | Counter-read strobe |
| cnt_value | output | 16 | Current count |
| fast_clr | input | 1 | Fast-clear mode |
| cap_evt | input | 4 | Per-channel capture event |
| cap_edge | input | 4 | Per-channel edge direction, 1 = rising |
| latch_rd | input | 4 | Per-channel capture latch read strobe |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The flag's set event (the count stepping from 1 to 0) and a software clear can land on the same edge. The bench provokes this by loading a short period and then issuing a one-to-bit-7 status write in the cycle where the count shows 1. It judges the result by reading the flag one cycle later, where it must still be set. A second coincidence comes from driving a latch read and a capture on one channel together. The bench judges it by checking that the event is recorded and that a following opposite edge is ignored.

// File: rtl/mdcnt_pkg.sv
package mdcnt_pkg;
  localparam int CNT_W  = 16;
  localparam int N_CH   = 4;
  localparam int DIV_W  = 4;
  localparam int STAT_W = 8;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    RATE_DIV1  = 2'd0,
    RATE_DIV4  = 2'd1,
    RATE_DIV8  = 2'd2,
    RATE_DIV16 = 2'd3
  } rate_e;

  function automatic logic [DIV_W-1:0] rate_term(input rate_e r);
    case (r)
      RATE_DIV1:  rate_term = DIV_W'(0);
      RATE_DIV4:  rate_term = DIV_W'(3);
      RATE_DIV8:  rate_term = DIV_W'(7);
      default:    rate_term = DIV_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/mdcnt_prescaler.sv
module mdcnt_prescaler
  import mdcnt_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_we,
  input  logic [1:0] sel_wdata,
  input  logic       restart,
  output logic       tick
);
  rate_e         sel_q, sel_d;
  logic [DW-1:0] pcnt_q, pcnt_d;
  logic [DW-1:0] term;

  always_comb begin
    term = rate_term(sel_q);
    tick = (pcnt_q == term);
  end

  always_comb begin
    sel_d  = sel_q;
    pcnt_d = pcnt_q + DW'(1);
    if (sel_we) sel_d = rate_e'(sel_wdata);
    if (sel_we || restart || tick) pcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= RATE_DIV1;
      pcnt_q <= '0;
    end else begin
      sel_q  <= sel_d;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/mdcnt_counter.sv
module mdcnt_counter
  import mdcnt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load_we,
  input  logic [W-1:0] load_wdata,
  output logic [W-1:0] count,
  output logic         wrap_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] mod_q, mod_d;
  logic         at_zero;

  always_comb begin
    at_zero  = (cnt_q == '0);
    mod_d    = mod_q;
    cnt_d    = cnt_q;
    wrap_evt = 1'b0;
    if (load_we) begin
      mod_d = load_wdata;
      cnt_d = load_wdata;
    end else if (tick) begin
      if (at_zero) begin
        cnt_d = mod_q;
      end else begin
        cnt_d    = cnt_q - ONE;
        wrap_evt = (cnt_q == ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      mod_q <= mod_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/mdcnt_polarity.sv
module mdcnt_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic edge_rise,
  input  logic rearm,
  output logic pol
);
  logic armed_q, armed_d;
  logic pol_q, pol_d;
  logic take;

  always_comb begin
    take    = evt && (armed_q || rearm);
    pol_d   = pol_q;
    armed_d = armed_q;
    if (take) begin
      pol_d   = edge_rise;
      armed_d = 1'b0;
    end else if (rearm) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      pol_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pol_q   <= pol_d;
    end
  end

  assign pol = pol_q;
endmodule

// File: rtl/mdcnt_flag.sv
module mdcnt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_one,
  input  logic rd_strobe,
  input  logic fast_mode,
  output logic flag
);
  logic flag_q, flag_d;
  logic clr;

  always_comb begin
    clr    = fast_mode ? rd_strobe : wr_one;
    flag_d = flag_q;
    if (clr)     flag_d = 1'b0;
    if (set_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/mdcnt_top.sv
module mdcnt_top
  import mdcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              presel_we,
  input  logic [1:0]        presel_wdata,
  input  logic              load_we,
  input  logic [CNT_W-1:0]  load_wdata,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] stat_rdata,
  input  logic              cnt_rd,
  output logic [CNT_W-1:0]  cnt_value,
  input  logic              fast_clr,
  input  logic [N_CH-1:0]   cap_evt,
  input  logic [N_CH-1:0]   cap_edge,
  input  logic [N_CH-1:0]   latch_rd,
  input  logic              irq_en,
  output logic              irq
);
  localparam int PAD_W = FLAG_BIT - N_CH;

  logic            tick;
  logic            wrap_evt;
  logic            flag;
  logic [N_CH-1:0] pol;
  logic            unused_wbits;

  assign unused_wbits = ^stat_wdata[FLAG_BIT-1:0];

  mdcnt_prescaler #(.DW(DIV_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (presel_we),
    .sel_wdata (presel_wdata),
    .restart   (load_we),
    .tick      (tick)
  );

  mdcnt_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load_we    (load_we),
    .load_wdata (load_wdata),
    .count      (cnt_value),
    .wrap_evt   (wrap_evt)
  );

  mdcnt_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_evt   (wrap_evt),
    .wr_one    (stat_we && stat_wdata[FLAG_BIT]),
    .rd_strobe (cnt_rd),
    .fast_mode (fast_clr),
    .flag      (flag)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    mdcnt_polarity u_pol (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (cap_evt[c]),
      .edge_rise (cap_edge[c]),
      .rearm     (latch_rd[c]),
      .pol       (pol[c])
    );
  end

  assign stat_rdata = {flag, {PAD_W{1'b0}}, pol};
  assign irq        = flag && irq_en;
endmodule

// File: rtl/mdcnt_checker.sv
module mdcnt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        load_we,
  input logic        stat_we,
  input logic [7:0]  stat_wdata,
  input logic        cnt_rd,
  input logic        fast_clr,
  input logic [3:0]  cap_evt,
  input logic        irq_en,
  input logic        irq,
  input logic [7:0]  stat_rdata,
  input logic [15:0] cnt_value
);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_rdata[7] && irq_en));

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[6:4] == 3'b000);

  p_wrap_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && cnt_value == 16'd1) |=> (cnt_value == 16'd1 || stat_rdata[7]));

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[7] && !fast_clr && !(stat_we && stat_wdata[7])) |=> stat_rdata[7]);

  p_fast_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[7] && fast_clr && !cnt_rd) |=> stat_rdata[7]);

  p_pol_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt == 4'b0000) |=> $stable(stat_rdata[3:0]));
endmodule

bind mdcnt_top mdcnt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_we    (load_we),
  .stat_we    (stat_we),
  .stat_wdata (stat_wdata),
  .cnt_rd     (cnt_rd),
  .fast_clr   (fast_clr),
  .cap_evt    (cap_evt),
  .irq_en     (irq_en),
  .irq        (irq),
  .stat_rdata (stat_rdata),
  .cnt_value  (cnt_value)
);

// File: tb/mdcnt_top_test.sv
module mdcnt_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        presel_we = 1'b0;
  logic [1:0]  presel_wdata = '0;
  logic        load_we = 1'b0;
  logic [15:0] load_wdata = '0;
  logic        stat_we = 1'b0;
  logic [7:0]  stat_wdata = '0;
  logic [7:0]  stat_rdata;
  logic        cnt_rd = 1'b0;
  logic [15:0] cnt_value;
  logic        fast_clr = 1'b0;
  logic [3:0]  cap_evt = '0;
  logic [3:0]  cap_edge = '0;
  logic [3:0]  latch_rd = '0;
  logic        irq_en = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [3:0] exp_pol = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdcnt_top uut (
    .clk(clk), .rst_n(rst_n), .presel_we(presel_we), .presel_wdata(presel_wdata),
    .load_we(load_we), .load_wdata(load_wdata), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .cnt_rd(cnt_rd),
    .cnt_value(cnt_value), .fast_clr(fast_clr), .cap_evt(cap_evt),
    .cap_edge(cap_edge), .latch_rd(latch_rd), .irq_en(irq_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] v);
    load_we = 1'b1; load_wdata = v;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] v);
    stat_we = 1'b1; stat_wdata = v;
    @(negedge clk);
    stat_we = 1'b0;
  endtask

  task automatic rd_cnt();
    cnt_rd = 1'b1;
    @(negedge clk);
    cnt_rd = 1'b0;
  endtask

  task automatic capture(input int ch, input logic rise, input logic rd);
    cap_evt[ch] = 1'b1; cap_edge[ch] = rise; latch_rd[ch] = rd;
    @(negedge clk);
    cap_evt = '0; latch_rd = '0;
  endtask

  task automatic make_flag();
    do_load(16'd2);
    repeat (2) @(negedge clk);
    do_load(16'd1000);
  endtask

  task automatic t_reset();
    check("R9 reset status", stat_rdata, 8'h00);
    check("R9 reset count", cnt_value, 16'h0);
    check("R10 reset irq", irq, 1'b0);
  endtask

  task automatic t_rates();
    for (int code = 0; code < 4; code++) begin
      int div;
      div = (code == 0) ? 1 : (4 << (code - 1));
      presel_we = 1'b1; presel_wdata = 2'(code);
      @(negedge clk);
      presel_we = 1'b0;
      do_load(16'd100);
      check("R2 load value", cnt_value, 16'd100);
      repeat (3*div - 1) @(negedge clk);
      check("R1 before third step", cnt_value, 16'd98);
      @(negedge clk);
      check("R1 third step", cnt_value, 16'd97);
    end
    presel_we = 1'b1; presel_wdata = 2'd0;
    @(negedge clk);
    presel_we = 1'b0;
  endtask

  task automatic t_wrap();
    do_load(16'd3);
    repeat (2) @(negedge clk);
    check("R3 count at one", cnt_value, 16'd1);
    check("R3 flag not yet", stat_rdata[7], 1'b0);
    @(negedge clk);
    check("R3 count zero", cnt_value, 16'd0);
    check("R3 flag set", stat_rdata[7], 1'b1);
    irq_en = 1'b1; #1;
    check("R10 irq on", irq, 1'b1);
    irq_en = 1'b0; #1;
    check("R10 irq gated", irq, 1'b0);
    @(negedge clk);
    check("R3 reload", cnt_value, 16'd3);
    do_load(16'd1000);
    wr_stat(8'h80);
    check("R4 write one clears", stat_rdata[7], 1'b0);
    do_load(16'd0);
    repeat (6) @(negedge clk);
    check("R3 zero modulus count", cnt_value, 16'd0);
    check("R3 zero modulus flag", stat_rdata[7], 1'b0);
  endtask

  task automatic t_clear_modes();
    make_flag();
    wr_stat(8'h00);
    check("R4 write zero keeps", stat_rdata[7], 1'b1);
    rd_cnt();
    check("R4 read ignored in normal mode", stat_rdata[7], 1'b1);
    fast_clr = 1'b1;
    wr_stat(8'h80);
    check("R5 write one ignored in fast", stat_rdata[7], 1'b1);
    rd_cnt();
    check("R5 read clears in fast", stat_rdata[7], 1'b0);
    fast_clr = 1'b0;
  endtask

  task automatic t_set_wins();
    make_flag();
    wr_stat(8'h80);
    check("R6 precondition clear", stat_rdata[7], 1'b0);
    do_load(16'd2);
    @(negedge clk);
    check("R6 count at one", cnt_value, 16'd1);
    wr_stat(8'h80);
    check("R6 set beats clear", stat_rdata[7], 1'b1);
    do_load(16'd1000);
    wr_stat(8'h80);
  endtask

  task automatic t_polarity();
    capture(0, 1'b1, 1'b0); exp_pol[0] = 1'b1;
    check("R7 first rising", stat_rdata[3:0], exp_pol);
    capture(0, 1'b0, 1'b0);
    check("R7 later ignored", stat_rdata[3:0], exp_pol);
    latch_rd[0] = 1'b1;
    @(negedge clk);
    latch_rd = '0;
    capture(0, 1'b0, 1'b0); exp_pol[0] = 1'b0;
    check("R7 after latch read falling", stat_rdata[3:0], exp_pol);
    capture(3, 1'b1, 1'b0); exp_pol[3] = 1'b1;
    check("R9 channel 3 at bit 3", stat_rdata, {4'h0, exp_pol});
    capture(1, 1'b1, 1'b0); exp_pol[1] = 1'b1;
    capture(1, 1'b0, 1'b1); exp_pol[1] = 1'b0;
    check("R8 same cycle read and capture", stat_rdata[3:0], exp_pol);
    capture(1, 1'b1, 1'b0);
    check("R8 disarmed after", stat_rdata[3:0], exp_pol);
    wr_stat(8'h7F);
    check("R9 writes to low bits ignored", stat_rdata, {4'h0, exp_pol});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_polarity();
    t_rates();
    t_wrap();
    t_clear_modes();
    t_set_wins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule